// File: doc/BRIEF.md
# Processing-Element Operand Source Stage

This block sits between one input port of a processing element and the ALU operand that the port feeds. A configured two-bit source mode picks where the operand comes from: a stored configuration constant, a copy of the input registered one cycle earlier, a register that only loads when a capture strobe is high, or the raw input passed straight through. One copy of the block is placed for each of the element's five inputs. Each copy has its own mode and constant, and its width is set per copy: 16 for data inputs, 1 for bit inputs.

The mode and the constant are loaded through a small configuration port with separate write strobes. Both land on the next rising clock edge. The capture-gated mode lets the operand register keep its contents while the clock is gated during configuration. The stored register, the constant and the mode all clear to zero on an asynchronous active-low reset.

The mode acts as the block's state. The four states are SRC_CONST (encoding 0), SRC_GATED (1), SRC_PASS (2) and SRC_DELAY (3). A transition happens only on a clock edge where `cfg_mode_we` is high, and it moves to the state encoded on `cfg_mode`. Any state can reach any other. Reset forces SRC_CONST.

Top module: `pe_operand_stage`

## Requirements
- R1: While `rst_n` is low, `op_out` is 0 without waiting for a clock edge. Reset also clears the stored register and the constant, and sets the mode to SRC_CONST (0).
- R2: In SRC_CONST (mode 0), `op_out` equals the configured constant whatever value `in_data` has.
- R3: A constant write (`cfg_const_we` high) becomes visible on the rising edge where the strobe is sampled, and not earlier.
- R4: In SRC_DELAY (mode 3), `op_out` equals the `in_data` value sampled at the previous rising edge. A change on `in_data` does not reach `op_out` before that edge.
- R5: In SRC_GATED (mode 1), the register loads `in_data` on an edge where `in_capture` is high. On an edge where it is low, the register keeps its value, and `op_out` shows the stored value.
- R6: In SRC_PASS (mode 2), `op_out` follows `in_data` combinationally.
- R7: A mode write (`cfg_mode_we` high) takes effect on the edge where it is sampled. The encodings are 0 constant, 1 gated, 2 pass and 3 delay.
- R8: In SRC_DELAY, `in_capture` has no effect, and the register loads on every edge.
- R9: A constant write does not disturb the stored register. In SRC_CONST and SRC_PASS the stored register keeps its value, which reappears when the mode returns to SRC_GATED with `in_capture` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_we | input | 1 | Write strobe for the source mode |
| cfg_mode | input | 2 | Source mode to write (0 const, 1 gated, 2 pass, 3 delay) |
| cfg_const_we | input | 1 | Write strobe for the constant |
| cfg_const | input | W | Constant value to write |
| in_data | input | W | Operand input from the routing network |
| in_capture | input | 1 | Capture strobe used in gated mode |
| op_out | output | W | Operand delivered to the ALU |

## Verification
Pass-through results are due in the same cycle, so they are sampled one time step after the input changes, with no clock edge between. Delayed, gated, constant and mode results are due one rising edge after the stimulus. The bench drives inputs on the falling edge and checks on the next falling edge. For the delay path it also checks just before the edge, to show that no zero-latency path exists. Reset is checked a time step after `rst_n` falls, away from any edge, to show that it acts without a clock.

// File: rtl/pe_operand_pkg.sv
package pe_operand_pkg;
    typedef enum logic [1:0] {
        SRC_CONST = 2'd0,
        SRC_GATED = 2'd1,
        SRC_PASS  = 2'd2,
        SRC_DELAY = 2'd3
    } src_mode_e;
endpackage

// File: rtl/pe_operand_cfg.sv
module pe_operand_cfg
    import pe_operand_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [1:0]   mode_wdata,
    input  logic         const_we,
    input  logic [W-1:0] const_wdata,
    output src_mode_e    mode_q,
    output logic [W-1:0] const_q
);
    // Mode register: this is the stage's state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= SRC_CONST;
        end else if (mode_we) begin
            mode_q <= src_mode_e'(mode_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            const_q <= '0;
        end else if (const_we) begin
            const_q <= const_wdata;
        end
    end
endmodule

// File: rtl/pe_operand_hold.sv
module pe_operand_hold
    import pe_operand_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  src_mode_e    mode,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic load;

    always_comb begin
        unique case (mode)
            SRC_DELAY: load = 1'b1;
            SRC_GATED: load = capture;
            SRC_CONST: load = 1'b0;
            SRC_PASS:  load = 1'b0;
            default:   load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pe_operand_mux.sv
module pe_operand_mux
    import pe_operand_pkg::*;
#(
    parameter int W = 16
) (
    input  src_mode_e    mode,
    input  logic [W-1:0] const_val,
    input  logic [W-1:0] held_val,
    input  logic [W-1:0] live_val,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (mode)
            SRC_CONST: y = const_val;
            SRC_GATED: y = held_val;
            SRC_PASS:  y = live_val;
            SRC_DELAY: y = held_val;
            default:   y = const_val;
        endcase
    end
endmodule

// File: rtl/pe_operand_stage.sv
module pe_operand_stage
    import pe_operand_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_mode_we,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_const_we,
    input  logic [W-1:0] cfg_const,
    input  logic [W-1:0] in_data,
    input  logic         in_capture,
    output logic [W-1:0] op_out
);
    src_mode_e    mode_q;
    logic [W-1:0] const_q;
    logic [W-1:0] held_q;

    pe_operand_cfg #(.W(W)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_we     (cfg_mode_we),
        .mode_wdata  (cfg_mode),
        .const_we    (cfg_const_we),
        .const_wdata (cfg_const),
        .mode_q      (mode_q),
        .const_q     (const_q)
    );

    pe_operand_hold #(.W(W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .capture (in_capture),
        .d       (in_data),
        .q       (held_q)
    );

    pe_operand_mux #(.W(W)) mux_i (
        .mode      (mode_q),
        .const_val (const_q),
        .held_val  (held_q),
        .live_val  (in_data),
        .y         (op_out)
    );
endmodule

// File: rtl/pe_operand_stage_chk.sv
module pe_operand_stage_chk
    import pe_operand_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_const_we,
    input logic [W-1:0] cfg_const,
    input logic [W-1:0] in_data,
    input logic         in_capture,
    input logic [W-1:0] op_out,
    input src_mode_e    mode_q,
    input logic [W-1:0] const_q
);
    // R2: a constant source stays steady unless the constant was rewritten
    p_const_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRC_CONST && $past(mode_q) == SRC_CONST && !$past(cfg_const_we))
        |-> $stable(op_out));

    // R3: a constant write lands on the edge where it is sampled
    p_const_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_const_we) |-> const_q == $past(cfg_const));

    // R4: the delay source returns the input of the previous edge
    p_delay_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRC_DELAY && $past(mode_q) == SRC_DELAY)
        |-> op_out == $past(in_data));

    // R5: the gated source holds while the capture strobe is low
    p_gated_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRC_GATED && $past(mode_q) == SRC_GATED && !$past(in_capture))
        |-> $stable(op_out));

    // R5: the gated source loads while the capture strobe is high
    p_gated_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SRC_GATED && $past(mode_q) == SRC_GATED && $past(in_capture))
        |-> op_out == $past(in_data));

    // R6: the pass source follows the input
    p_pass_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == SRC_PASS |-> op_out == in_data);
endmodule

bind pe_operand_stage pe_operand_stage_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_const_we (cfg_const_we),
    .cfg_const    (cfg_const),
    .in_data      (in_data),
    .in_capture   (in_capture),
    .op_out       (op_out),
    .mode_q       (mode_q),
    .const_q      (const_q)
);

// File: tb/pe_operand_stage_tb_top.sv
`timescale 1ns/1ps
module pe_operand_stage_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_mode_we = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         cfg_const_we = 1'b0;
    logic [W-1:0] cfg_const = '0;
    logic [W-1:0] in_data = '0;
    logic         in_capture = 1'b0;
    logic [W-1:0] op_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pe_operand_stage #(.W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode_we  (cfg_mode_we),
        .cfg_mode     (cfg_mode),
        .cfg_const_we (cfg_const_we),
        .cfg_const    (cfg_const),
        .in_data      (in_data),
        .in_capture   (in_capture),
        .op_out       (op_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: op_out=%0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg_mode_we = 1'b1;
        cfg_mode = m;
        tick();
        cfg_mode_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] held;
        in_data = 8'hA5;
        #3;
        chk("R1 reset output", op_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 post-reset const", op_out, '0);

        // R3: constant lands on the sampled edge
        cfg_const_we = 1'b1;
        cfg_const = 8'd1;
        #1;
        chk("R3 before edge", op_out, 8'd0);
        tick();
        cfg_const_we = 1'b0;
        chk("R3 after edge", op_out, 8'd1);

        // R2: constant independent of input
        for (int v = 0; v < 256; v++) begin
            in_data = v[W-1:0];
            #1;
            chk("R2 const ignores input", op_out, 8'd1);
        end
        tick();
        chk("R2 const after clock", op_out, 8'd1);

        // R7 / R4 / R8: delay mode
        set_mode(2'd3);
        prev = in_data;
        tick();
        chk("R7 delay entered", op_out, prev);
        for (int v = 0; v < 256; v++) begin
            in_data = v[W-1:0] ^ 8'h96;
            in_capture = v[0];
            #1;
            chk("R4 no zero latency", op_out, prev);
            tick();
            chk("R8 delay loads regardless of capture", op_out, v[W-1:0] ^ 8'h96);
            prev = v[W-1:0] ^ 8'h96;
        end

        // R9: constant write leaves delay register alone
        in_data = 8'h3C;
        tick();
        cfg_const_we = 1'b1;
        cfg_const = 8'h77;
        tick();
        cfg_const_we = 1'b0;
        chk("R9 const write no disturb", op_out, 8'h3C);

        // R5: gated mode; write edge still loads (mode was delay)
        in_data = 8'h11;
        set_mode(2'd1);
        held = 8'h11;
        chk("R7 gated entered", op_out, held);
        for (int i = 0; i < 256; i++) begin
            in_data = i[W-1:0] ^ 8'h5A;
            in_capture = (i % 3 == 0);
            tick();
            if (i % 3 == 0) held = i[W-1:0] ^ 8'h5A;
            chk("R5 gated load/hold", op_out, held);
        end

        // R6: pass mode; write edge with capture low keeps held
        in_capture = 1'b0;
        set_mode(2'd2);
        for (int v = 0; v < 256; v++) begin
            in_data = v[W-1:0];
            #1;
            chk("R6 pass follows", op_out, v[W-1:0]);
        end
        in_capture = 1'b1;
        tick();
        in_capture = 1'b0;

        // R9: back to gated, held value reappears
        set_mode(2'd1);
        chk("R9 held across pass", op_out, held);

        // R2 revisit with the new constant
        set_mode(2'd0);
        chk("R2 new constant", op_out, 8'h77);

        // R1: asynchronous reset mid-run in delay mode
        set_mode(2'd3);
        in_data = 8'hEE;
        tick();
        chk("R4 before reset", op_out, 8'hEE);
        #1;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset clears", op_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 mode back to const", op_out, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule